// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is addressed to this station. It watches the receive byte stream as the first six bytes arrive, builds the 48-bit destination address one byte at a time and, in the same pass, folds the address bits into a 6-bit hash index. It then reaches one decision from four sources: a programmable 64-bit hash table, a set of specific-address slots, the broadcast address, and a copy-everything mode.

The hash table is split into separate unicast and multicast paths. The group bit of the address picks the path, and each path has its own enable. The decision appears as a one-cycle `dec_valid` pulse in the cycle after the sixth address byte. It comes with the accept flag and the reason flags. Those flags hold their values until the next decision. Checking the frame check sequence and handling receive buffers are left to neighbouring blocks.

Top module: `da_hash_filter`

## Requirements
- R1: A byte is taken only in a cycle with `rx_valid` high. A byte with `rx_valid` and `rx_sof` both high is address byte 0, even while an earlier address is only partly received, which discards that earlier address. Idle cycles between address bytes are allowed. `dec_valid` is high for exactly one cycle, the cycle after the edge that takes address byte 5.
- R2: Address bit n is bit (n mod 8) of address byte (n div 8), so bit 0 is the least significant bit of the first byte. Hash index bit k (k = 0..5) is the XOR of address bits k, k+6, k+12, ..., k+42.
- R3: The hash table is `{hash_hi, hash_lo}`, and a hash index of n selects bit n of it. Indices 0..31 fall in `hash_lo` and 32..63 fall in `hash_hi`.
- R4: When address bit 0 is 1 (group address), `dec_hash_hit` is 1 exactly when `cfg_multi_hash_en` is 1 and the selected table bit is 1. With all 64 table bits set and `cfg_multi_hash_en` high, every group address is accepted.
- R5: When address bit 0 is 0, `dec_hash_hit` is 1 exactly when `cfg_uni_hash_en` is 1 and the selected table bit is 1.
- R6: With `cfg_copy_all` high, every frame is accepted, whatever the hash or address matching gives.
- R7: The all-ones address sets `dec_broadcast` and is always accepted.
- R8: Slot s holds the low word `slot_lo[32s+31:32s]`, with address byte 0 in bits 7:0 up to byte 3 in bits 31:24, and the high word `slot_hi[16s+15:16s]`, with byte 4 in bits 7:0 and byte 5 in bits 15:8. `dec_addr_hit` is 1 when some slot with its `slot_en` bit set equals the address.
- R9: `dec_multicast` equals address bit 0. All `dec_*` result flags keep their values between decisions.
- R10: After reset, `dec_valid` and every result flag are 0.
- R11: Bytes after address byte 5 have no effect until the next `rx_sof`. Bytes taken without a preceding `rx_sof` are ignored.
- R12: `dec_accept` is the OR of `dec_hash_hit`, `dec_addr_hit`, `dec_broadcast` and copy-all. No other condition accepts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Receive data byte |
| cfg_copy_all | input | 1 | Accept every frame |
| cfg_uni_hash_en | input | 1 | Enable hash matching for individual addresses |
| cfg_multi_hash_en | input | 1 | Enable hash matching for group addresses |
| hash_lo | input | 32 | Hash table bits 31:0 |
| hash_hi | input | 32 | Hash table bits 63:32 |
| slot_lo | input | 32*NUM_SLOTS | Specific-address low words, address bytes 0..3 |
| slot_hi | input | 16*NUM_SLOTS | Specific-address high words, address bytes 4..5 |
| slot_en | input | NUM_SLOTS | Enable for each specific-address slot |
| dec_valid | output | 1 | One-cycle pulse marking a new decision |
| dec_accept | output | 1 | Frame accepted |
| dec_multicast | output | 1 | Address bit 0, the group bit |
| dec_hash_hit | output | 1 | Hash table match |
| dec_addr_hit | output | 1 | Specific-address slot match |
| dec_broadcast | output | 1 | Address is all ones |

## Verification
The assertions assume that the configuration inputs and the hash and slot words are quasi-static. They are sampled in the cycle that takes the last address byte, and the properties relate the flags to the values held on the cycle before `dec_valid`. The stimulus changes configuration only between frames, after the latching edge. The stimulus also makes sure that six bytes separate any two decisions. The scenarios cover restart on `rx_sof`, idle gaps, trailing bytes and single-bit addresses.

// File: rtl/da_filt_pkg.sv
package da_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int IDX_W      = 6;
  localparam int POS_W      = 3;
  localparam int TABLE_BITS = 1 << IDX_W;

  // Fold one address byte at position pos into the hash index bits it touches.
  function automatic logic [IDX_W-1:0] fold_byte(input logic [7:0] b,
                                                 input logic [POS_W-1:0] pos);
    logic [IDX_W-1:0] r;
    int unsigned k;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      k = (8 * int'(pos) + i) % IDX_W;
      r[k] = r[k] ^ b[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/da_filt_seq.sv
module da_filt_seq
  import da_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [POS_W-1:0] cur_pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic             active_q, active_d;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    take     = rx_valid & (rx_sof | active_q);
    cur_pos  = rx_sof ? '0 : pos_q;
    first    = take & (cur_pos == '0);
    last     = take & (cur_pos == LAST_POS);
    active_d = active_q;
    pos_d    = pos_q;
    if (take) begin
      if (cur_pos == LAST_POS) begin
        active_d = 1'b0;
        pos_d    = '0;
      end else begin
        active_d = 1'b1;
        pos_d    = cur_pos + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (take) begin
      active_q <= active_d;
      pos_q    <= pos_d;
    end
  end
endmodule

// File: rtl/da_filt_hash.sv
module da_filt_hash
  import da_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [7:0]       rx_byte,
  input  logic [31:0]      hash_lo,
  input  logic [31:0]      hash_hi,
  output logic [IDX_W-1:0] idx_now,
  output logic             table_bit
);
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_base;
  logic [TABLE_BITS-1:0] table_vec;

  always_comb begin
    idx_base  = first ? '0 : idx_q;
    idx_now   = idx_base ^ fold_byte(rx_byte, cur_pos);
    table_vec = {hash_hi, hash_lo};
    table_bit = table_vec[idx_now];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (take) idx_q <= idx_now;
  end
endmodule

// File: rtl/da_filt_slot_cmp.sv
module da_filt_slot_cmp
  import da_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first,
  input  logic [POS_W-1:0]        cur_pos,
  input  logic [7:0]              rx_byte,
  input  logic [32*NUM_SLOTS-1:0] slot_lo,
  input  logic [16*NUM_SLOTS-1:0] slot_hi,
  input  logic [NUM_SLOTS-1:0]    slot_en,
  output logic                    any_hit
);
  logic [NUM_SLOTS-1:0] hit_now;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [47:0] slot_addr;
    logic [7:0]  exp_byte;
    logic        ok_q, ok_now;

    always_comb begin
      slot_addr  = {slot_hi[16*s +: 16], slot_lo[32*s +: 32]};
      exp_byte   = slot_addr[8*cur_pos +: 8];
      ok_now     = (first | ok_q) & (rx_byte == exp_byte);
      hit_now[s] = ok_now & slot_en[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ok_q <= 1'b0;
      else if (take) ok_q <= ok_now;
    end
  end

  assign any_hit = |hit_now;
endmodule

// File: rtl/da_hash_filter.sv
module da_hash_filter
  import da_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_byte,
  input  logic                    cfg_copy_all,
  input  logic                    cfg_uni_hash_en,
  input  logic                    cfg_multi_hash_en,
  input  logic [31:0]             hash_lo,
  input  logic [31:0]             hash_hi,
  input  logic [32*NUM_SLOTS-1:0] slot_lo,
  input  logic [16*NUM_SLOTS-1:0] slot_hi,
  input  logic [NUM_SLOTS-1:0]    slot_en,
  output logic                    dec_valid,
  output logic                    dec_accept,
  output logic                    dec_multicast,
  output logic                    dec_hash_hit,
  output logic                    dec_addr_hit,
  output logic                    dec_broadcast
);
  logic             take, first, last;
  logic [POS_W-1:0] cur_pos;
  logic [IDX_W-1:0] idx_now;
  logic             table_bit;
  logic             slot_hit;

  logic grp_q, grp_now;
  logic ones_q, ones_now;
  logic hash_hit_d, accept_d;

  da_filt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .take(take), .first(first), .last(last), .cur_pos(cur_pos)
  );

  da_filt_hash u_hash (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .cur_pos(cur_pos),
    .rx_byte(rx_byte), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .idx_now(idx_now), .table_bit(table_bit)
  );

  da_filt_slot_cmp #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .cur_pos(cur_pos),
    .rx_byte(rx_byte), .slot_lo(slot_lo), .slot_hi(slot_hi),
    .slot_en(slot_en), .any_hit(slot_hit)
  );

  always_comb begin
    grp_now    = first ? rx_byte[0] : grp_q;
    ones_now   = (first | ones_q) & (&rx_byte);
    hash_hit_d = table_bit & (grp_now ? cfg_multi_hash_en : cfg_uni_hash_en);
    accept_d   = cfg_copy_all | ones_now | slot_hit | hash_hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= 1'b0;
      ones_q <= 1'b0;
    end else if (take) begin
      grp_q  <= grp_now;
      ones_q <= ones_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_valid <= 1'b0;
    else        dec_valid <= last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_accept    <= 1'b0;
      dec_multicast <= 1'b0;
      dec_hash_hit  <= 1'b0;
      dec_addr_hit  <= 1'b0;
      dec_broadcast <= 1'b0;
    end else if (last) begin
      dec_accept    <= accept_d;
      dec_multicast <= grp_now;
      dec_hash_hit  <= hash_hit_d;
      dec_addr_hit  <= slot_hit;
      dec_broadcast <= ones_now;
    end
  end

  logic unused_idx;
  assign unused_idx = ^idx_now;
endmodule

// File: rtl/da_filt_checker.sv
module da_filt_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic cfg_copy_all,
  input logic cfg_uni_hash_en,
  input logic cfg_multi_hash_en,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_multicast,
  input logic dec_hash_hit,
  input logic dec_addr_hit,
  input logic dec_broadcast
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  a_r1_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rx_valid));

  a_r4_multi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hash_hit && dec_multicast) |-> $past(cfg_multi_hash_en));

  a_r5_uni_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hash_hit && !dec_multicast) |-> $past(cfg_uni_hash_en));

  a_r6_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(cfg_copy_all)) |-> dec_accept);

  a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_broadcast) |-> (dec_accept && dec_multicast));

  a_r12_reason: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept) |->
      ($past(cfg_copy_all) || dec_hash_hit || dec_addr_hit || dec_broadcast));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ($stable(dec_accept) && $stable(dec_multicast) &&
                    $stable(dec_hash_hit) && $stable(dec_addr_hit) &&
                    $stable(dec_broadcast)));
endmodule

bind da_hash_filter da_filt_checker u_chk (.*);

// File: tb/da_hash_filter_tb_top.sv
module da_hash_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  typedef struct {
    logic  accept, mc, hash, addr, bcast;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_sof;
  logic [7:0] rx_byte;
  logic cfg_copy_all, cfg_uni_hash_en, cfg_multi_hash_en;
  logic [31:0] hash_lo, hash_hi;
  logic [32*NS-1:0] slot_lo;
  logic [16*NS-1:0] slot_hi;
  logic [NS-1:0] slot_en;
  logic dec_valid, dec_accept, dec_multicast, dec_hash_hit, dec_addr_hit, dec_broadcast;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  exp_t exp_q[$];
  exp_t last_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_hash_filter #(.NUM_SLOTS(NS)) dut_i (.*);

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [5:0] r = '0;
    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 8; m++) r[k] ^= da[k + 6*m];
    return r;
  endfunction

  function automatic exp_t model(input logic [47:0] da, input string tag);
    exp_t e;
    logic [63:0] tbl;
    logic tb_bit;
    tbl    = {hash_hi, hash_lo};
    tb_bit = tbl[ref_idx(da)];
    e.mc    = da[0];
    e.bcast = (da == 48'hFFFF_FFFF_FFFF);
    e.hash  = tb_bit & (da[0] ? cfg_multi_hash_en : cfg_uni_hash_en);
    e.addr  = 1'b0;
    for (int s = 0; s < NS; s++)
      if (slot_en[s] && {slot_hi[16*s +: 16], slot_lo[32*s +: 32]} == da) e.addr = 1'b1;
    e.accept = cfg_copy_all | e.bcast | e.hash | e.addr;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic sof);
    rx_valid = 1'b1; rx_sof = sof; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic send_frame(input logic [47:0] da, input string tag, input int gap);
    exp_q.push_back(model(da, tag));
    for (int j = 0; j < 6; j++) begin
      put_byte(da[8*j +: 8], j == 0);
      repeat (gap) @(posedge clk);
      #1;
    end
    @(posedge clk); #1;
  endtask

  // Monitor: compare each decision with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && dec_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected decision", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({dec_accept, dec_multicast, dec_hash_hit, dec_addr_hit, dec_broadcast} ==
              {e.accept, e.mc, e.hash, e.addr, e.bcast}, e.tag,
              "flags {acc,mc,hash,addr,bc}",
              {27'd0, dec_accept, dec_multicast, dec_hash_hit, dec_addr_hit, dec_broadcast},
              {27'd0, e.accept, e.mc, e.hash, e.addr, e.bcast});
        last_seen = e;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_byte = 0;
    cfg_copy_all = 0; cfg_uni_hash_en = 0; cfg_multi_hash_en = 0;
    hash_lo = 0; hash_hi = 0; slot_lo = '0; slot_hi = '0; slot_en = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check({dec_valid, dec_accept, dec_multicast, dec_hash_hit, dec_addr_hit, dec_broadcast} == 6'b0,
          "R10", "reset outputs", {26'd0, dec_valid, dec_accept, dec_multicast, dec_hash_hit,
          dec_addr_hit, dec_broadcast}, 0);
    @(posedge clk); #1;

    // R12: nothing enabled -> reject
    send_frame(48'h0A0B_0C0D_0E10, "R12", 0);
    // R4: multicast hash hit and gating
    a = 48'h5544_3322_1101;
    {hash_hi, hash_lo} = 64'd1 << ref_idx(a);
    cfg_multi_hash_en = 1;
    send_frame(a, "R4", 0);
    cfg_multi_hash_en = 0;
    send_frame(a, "R4", 0);
    // R5: unicast hash hit and gating
    a = 48'h5544_3322_1100;
    {hash_hi, hash_lo} = 64'd1 << ref_idx(a);
    cfg_uni_hash_en = 1;
    send_frame(a, "R5", 1);
    cfg_uni_hash_en = 0; cfg_multi_hash_en = 1;
    send_frame(a, "R5", 0);
    // R3: indices in the high half
    a = 48'h0;
    for (int t = 0; t < 400 && ref_idx(a) < 6'd32; t++) a = a + 48'h0000_0101_0102;
    {hash_hi, hash_lo} = 64'd1 << ref_idx(a);
    cfg_uni_hash_en = 1;
    send_frame(a, "R3", 0);
    {hash_hi, hash_lo} = ~(64'd1 << ref_idx(a));
    send_frame(a, "R3", 0);
    // R4: all ones table accepts any group address
    {hash_hi, hash_lo} = '1; cfg_uni_hash_en = 0; cfg_multi_hash_en = 1;
    send_frame(48'h1234_5678_9AB3, "R4", 0);
    send_frame(48'hFEDC_BA98_7655, "R4", 2);
    // R6: copy all
    {hash_hi, hash_lo} = '0; cfg_multi_hash_en = 0; cfg_copy_all = 1;
    send_frame(48'h0102_0304_0506, "R6", 0);
    cfg_copy_all = 0;
    // R7: broadcast
    send_frame(48'hFFFF_FFFF_FFFF, "R7", 0);
    // R8: specific slots
    slot_lo[32*2 +: 32] = 32'hDDCC_BBAA; slot_hi[16*2 +: 16] = 16'hFFEE;
    slot_en = 4'b0100;
    send_frame(48'hFFEE_DDCC_BBAA, "R8", 0);
    send_frame(48'hFFEE_DDCC_BBAB, "R8", 0);
    slot_en = 4'b1011;
    send_frame(48'hFFEE_DDCC_BBAA, "R8", 0);
    slot_en = 4'b0100;
    // R9: flags hold between decisions
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({dec_accept, dec_addr_hit} == {last_seen.accept, last_seen.addr}, "R9",
          "hold", {30'd0, dec_accept, dec_addr_hit}, {30'd0, last_seen.accept, last_seen.addr});
    @(posedge clk); #1;
    // R2: single-bit addresses over all 48 positions
    cfg_uni_hash_en = 1; cfg_multi_hash_en = 1;
    for (int b = 0; b < 48; b++) begin
      {hash_hi, hash_lo} = 64'd1 << (b % 6);
      send_frame(48'd1 << b, "R2", 0);
    end
    // R11: trailing bytes, and bytes without start marker
    {hash_hi, hash_lo} = '1;
    exp_q.push_back(model(48'h0000_0000_0002, "R11"));
    for (int j = 0; j < 10; j++) put_byte(j == 0 ? 8'h02 : 8'h00, j == 0);
    for (int j = 0; j < 6; j++) put_byte(8'hFF, 1'b0);
    repeat (3) @(posedge clk); #1;
    // R1: restart on start marker mid-address
    put_byte(8'hFF, 1'b1); put_byte(8'hFF, 1'b0); put_byte(8'hFF, 1'b0);
    {hash_hi, hash_lo} = '0;
    send_frame(48'h0000_0000_0004, "R1", 0);
    // R1: gaps within address
    send_frame(48'hFFFF_FFFF_FFFF, "R1", 3);
    // Mixed patterns
    for (int n = 0; n < 60; n++) begin
      logic [47:0] da;
      da = {$urandom, $urandom};
      hash_lo = $urandom; hash_hi = $urandom;
      cfg_uni_hash_en = 1'($urandom); cfg_multi_hash_en = 1'($urandom);
      cfg_copy_all = ($urandom % 8) == 0;
      if (n % 5 == 0) begin slot_lo[31:0] = da[31:0]; slot_hi[15:0] = da[47:32]; slot_en[0] = 1; end
      else slot_en[0] = 0;
      send_frame(da, "R12", n % 3);
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending decisions", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule